// File: doc/BRIEF.md
# Hot-Plug Slot Event Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream or root port, and decides when software must be told about slot events. Software reaches both registers through a dword-wide configuration write port with byte enables and a combinational read port. Three slot-side event inputs report a card being inserted, a card being removed and the attention button being pressed. A fourth input marks a card that is already present when the port comes out of reset.

Every register update feeds a single "pending" condition. That condition is true when hot-plug interrupts are enabled and at least one supported event status bit is set together with its own enable. Software is notified only when this condition changes value. The notification is a one-cycle message request that carries a 5-bit vector when either message-signalled interrupt mode is on. Otherwise it is the level of a legacy INTx line.

Each write that touches slot control counts as one command that completes at once. The electromechanical interlock is driven by a write-one pulse bit that toggles the interlock status. While the interlock is engaged, insert and remove requests are refused and flagged as busy.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, slot control reads 0x03C0 (both indicator fields at the off code 2'b11 in bits 7:6 and 9:8, all enables clear), slot status reads 0, and msg_req_o, intx_o and busy_o are 0.
- R2: A write to the slot dword (address SLOT_ADDR, byte lanes 0-1 = control) updates only control bits 0 (attention-button enable), 3 (presence-change enable), 4 (command-completed enable), 5 (hot-plug interrupt enable), 7:6 and 9:8 (indicators), per enabled byte; every other control bit, including the interlock command bit 11, reads 0.
- R3: A write with address SLOT_ADDR and either of byte enables 0 or 1 set sets status bit 4 (command completed) in the same update, even if the same write clears it through the status lanes; writes to other addresses change nothing.
- R4: Writing 1 to control bit 11 toggles status bit 7 (interlock engaged).
- R5: Status sits in byte lanes 2-3 (status bit n is data bit 16+n); bits 0, 3 and 4 are write-one-to-clear, and bits 6 and 7 ignore writes.
- R6: With the interlock released, insert sets status bit 6 (card present) and bit 3 (presence changed); remove clears bit 6 and sets bit 3; remove wins over insert in the same cycle; card_boot_i sets bit 6 without touching bit 3.
- R7: While status bit 7 is set, insert and remove leave bits 6 and 3 unchanged and busy_o pulses high for one cycle on the next clock.
- R8: An attention button press sets status bit 0.
- R9: Pending = control bit 5 AND any of (status & control) over bits 0, 3 and 4; an event raised in the same cycle as a write-one-to-clear of its own bit leaves the bit set.
- R10: With msix_en_i or msi_en_i high, msg_req_o pulses for one cycle, one clock after the pending condition changes value in either direction, with msg_vec_o equal to msg_num_i; raising an already-set event gives no pulse.
- R11: With both message modes off, intx_o takes the new pending value one clock after pending changes, and falls after a status write that leaves nothing pending.
- R12: The read port returns {status, control} at SLOT_ADDR and 0 at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_en_i | input | 1 | Configuration write strobe |
| cfg_wr_addr_i | input | ADDR_W | Dword write address |
| cfg_wr_be_i | input | 4 | Byte enables |
| cfg_wr_data_i | input | 32 | Write data |
| cfg_rd_addr_i | input | ADDR_W | Dword read address |
| cfg_rd_data_o | output | 32 | Read data, {status, control} |
| card_insert_i | input | 1 | Card inserted event |
| card_remove_i | input | 1 | Card removed event |
| card_boot_i | input | 1 | Card present at power-up, no event |
| attn_press_i | input | 1 | Attention button pressed |
| msix_en_i | input | 1 | MSI-X enabled |
| msi_en_i | input | 1 | MSI enabled |
| msg_num_i | input | VEC_W | Interrupt message number |
| msg_req_o | output | 1 | Message request pulse |
| msg_vec_o | output | VEC_W | Vector of the request |
| intx_o | output | 1 | Legacy interrupt level |
| busy_o | output | 1 | Insert/remove refused by interlock |

## Verification
Two functions can land on the same status bit in one cycle: a slot event that raises a bit, and a software write-one-to-clear or a command completion that affects the same bit. The bench provokes this directly with an insert that arrives together with a clear of the presence-changed bit, and with a single dword write that both clears command-completed and writes control. The random phase then fires events, writes and mode changes independently every cycle, so such overlaps recur many times. A reference model updates status with the clear first and the raise after, and it predicts each message pulse and each INTx level from the change in pending it computes itself.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int unsigned REG_W = 16;

  // status bit positions
  localparam int unsigned ABP_B = 0;
  localparam int unsigned PDC_B = 3;
  localparam int unsigned CC_B  = 4;
  localparam int unsigned PDS_B = 6;
  localparam int unsigned EIS_B = 7;

  // control bit positions
  localparam int unsigned HPIE_B = 5;
  localparam int unsigned EIC_B  = 11;

  localparam logic [REG_W-1:0] CTL_RW_MASK = 16'h03F9;
  localparam logic [REG_W-1:0] EVT_MASK    = 16'h0019;
  localparam logic [REG_W-1:0] CTL_RST     = 16'h03C0;

  typedef struct packed {
    logic             ctl_wr;
    logic             sts_wr;
    logic [REG_W-1:0] ctl_bm;
    logic [REG_W-1:0] sts_bm;
  } cfg_wr_t;
endpackage

// File: rtl/hp_cfg_decode.sv
module hp_cfg_decode
  import hp_slot_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] SLOT_ADDR = '0
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [3:0]        wr_be_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [REG_W-1:0]  ctl_i,
  input  logic [REG_W-1:0]  sts_i,
  output cfg_wr_t           wr_o,
  output logic [31:0]       rd_data_o
);
  localparam int unsigned NB = 4;

  logic        hit;
  logic [31:0] bm;

  assign hit = wr_en_i && (wr_addr_i == SLOT_ADDR);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign bm[8*b +: 8] = {8{wr_be_i[b]}};
  end

  assign wr_o.ctl_wr = hit && (|wr_be_i[1:0]);
  assign wr_o.sts_wr = hit && (|wr_be_i[3:2]);
  assign wr_o.ctl_bm = bm[15:0];
  assign wr_o.sts_bm = bm[31:16];

  assign rd_data_o = (rd_addr_i == SLOT_ADDR) ? {sts_i, ctl_i} : 32'h0;
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_wr_t          wr_i,
  input  logic [31:0]      wdata_i,
  input  logic             insert_i,
  input  logic             remove_i,
  input  logic             boot_i,
  input  logic             button_i,
  output logic [REG_W-1:0] ctl_o,
  output logic [REG_W-1:0] sts_o,
  output logic             sts_touch_o,
  output logic             busy_o
);
  logic [REG_W-1:0] ctl_q, ctl_d, sts_q, sts_d;
  logic             busy_d;
  logic [REG_W-1:0] cw, sw;

  assign cw = wdata_i[15:0];
  assign sw = wdata_i[31:16];

  always_comb begin
    ctl_d  = ctl_q;
    sts_d  = sts_q;
    busy_d = 1'b0;
    // clears first, raises after: a raise in the same cycle survives
    if (wr_i.sts_wr) sts_d = sts_d & ~(sw & wr_i.sts_bm & EVT_MASK);
    if (wr_i.ctl_wr) begin
      ctl_d = (ctl_q & ~(CTL_RW_MASK & wr_i.ctl_bm)) | (cw & wr_i.ctl_bm & CTL_RW_MASK);
      if (cw[EIC_B] && wr_i.ctl_bm[EIC_B]) sts_d[EIS_B] = ~sts_q[EIS_B];
      sts_d[CC_B] = 1'b1;
    end
    if (boot_i) sts_d[PDS_B] = 1'b1;
    if (insert_i || remove_i) begin
      if (sts_q[EIS_B]) begin
        busy_d = 1'b1;
      end else begin
        sts_d[PDS_B] = !remove_i;
        sts_d[PDC_B] = 1'b1;
      end
    end
    if (button_i) sts_d[ABP_B] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q       <= CTL_RST;
      sts_q       <= '0;
      sts_touch_o <= 1'b0;
      busy_o      <= 1'b0;
    end else begin
      ctl_q       <= ctl_d;
      sts_q       <= sts_d;
      sts_touch_o <= wr_i.sts_wr;
      busy_o      <= busy_d;
    end
  end

  assign ctl_o = ctl_q;
  assign sts_o = sts_q;
endmodule

// File: rtl/hp_notify.sv
module hp_notify
  import hp_slot_pkg::*;
#(
  parameter int unsigned VEC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] ctl_i,
  input  logic [REG_W-1:0] sts_i,
  input  logic             sts_touch_i,
  input  logic             msix_en_i,
  input  logic             msi_en_i,
  input  logic [VEC_W-1:0] msg_num_i,
  output logic             pend_o,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             intx_o
);
  logic pend_q, chg, msg_mode;

  assign pend_o   = ctl_i[HPIE_B] && (|(sts_i & ctl_i & EVT_MASK));
  assign chg      = pend_o != pend_q;
  assign msg_mode = msix_en_i || msi_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      req_o  <= 1'b0;
      vec_o  <= '0;
      intx_o <= 1'b0;
    end else begin
      pend_q <= pend_o;
      req_o  <= chg && msg_mode;
      if (chg && msg_mode) vec_o <= msg_num_i;
      if (!msg_mode) begin
        if (chg) intx_o <= pend_o;
        else if (sts_touch_i && !pend_o) intx_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter logic [ADDR_W-1:0] SLOT_ADDR = 10'h006,
  parameter int unsigned VEC_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_en_i,
  input  logic [ADDR_W-1:0] cfg_wr_addr_i,
  input  logic [3:0]        cfg_wr_be_i,
  input  logic [31:0]       cfg_wr_data_i,
  input  logic [ADDR_W-1:0] cfg_rd_addr_i,
  output logic [31:0]       cfg_rd_data_o,
  input  logic              card_insert_i,
  input  logic              card_remove_i,
  input  logic              card_boot_i,
  input  logic              attn_press_i,
  input  logic              msix_en_i,
  input  logic              msi_en_i,
  input  logic [VEC_W-1:0]  msg_num_i,
  output logic              msg_req_o,
  output logic [VEC_W-1:0]  msg_vec_o,
  output logic              intx_o,
  output logic              busy_o
);
  cfg_wr_t          wr_s;
  logic [REG_W-1:0] ctl_q, sts_q;
  logic             sts_touch, pend_now;

  hp_cfg_decode #(.ADDR_W(ADDR_W), .SLOT_ADDR(SLOT_ADDR)) u_dec (
    .wr_en_i  (cfg_wr_en_i),
    .wr_addr_i(cfg_wr_addr_i),
    .wr_be_i  (cfg_wr_be_i),
    .rd_addr_i(cfg_rd_addr_i),
    .ctl_i    (ctl_q),
    .sts_i    (sts_q),
    .wr_o     (wr_s),
    .rd_data_o(cfg_rd_data_o)
  );

  hp_slot_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_s),
    .wdata_i    (cfg_wr_data_i),
    .insert_i   (card_insert_i),
    .remove_i   (card_remove_i),
    .boot_i     (card_boot_i),
    .button_i   (attn_press_i),
    .ctl_o      (ctl_q),
    .sts_o      (sts_q),
    .sts_touch_o(sts_touch),
    .busy_o     (busy_o)
  );

  hp_notify #(.VEC_W(VEC_W)) u_ntf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_i      (ctl_q),
    .sts_i      (sts_q),
    .sts_touch_i(sts_touch),
    .msix_en_i  (msix_en_i),
    .msi_en_i   (msi_en_i),
    .msg_num_i  (msg_num_i),
    .pend_o     (pend_now),
    .req_o      (msg_req_o),
    .vec_o      (msg_vec_o),
    .intx_o     (intx_o)
  );
endmodule

// File: rtl/hp_slot_chk.sv
module hp_slot_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctl_wr,
  input logic        eic_wr,
  input logic [15:0] sts_q,
  input logic        insert,
  input logic        remove,
  input logic        boot,
  input logic        busy,
  input logic        msg_req,
  input logic        msg_mode,
  input logic        pend_now
);
  AST_CMD_COMPLETES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr |=> sts_q[4]); // R3

  AST_INTERLOCK_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && eic_wr) |=> (sts_q[7] != $past(sts_q[7]))); // R4

  AST_INSERT_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insert && !remove && !sts_q[7]) |=> (sts_q[6] && sts_q[3])); // R6

  AST_LOCKED_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q[7] && (insert || remove) && !boot) |=> (busy && $stable(sts_q[6]))); // R7

  AST_REQ_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_req |-> $past(msg_mode)); // R10

  AST_REQ_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_req |-> ($past(pend_now) != $past(pend_now, 2))); // R10
endmodule

bind hp_slot_ctrl hp_slot_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ctl_wr  (wr_s.ctl_wr),
  .eic_wr  (cfg_wr_data_i[11] && cfg_wr_be_i[1]),
  .sts_q   (sts_q),
  .insert  (card_insert_i),
  .remove  (card_remove_i),
  .boot    (card_boot_i),
  .busy    (busy_o),
  .msg_req (msg_req_o),
  .msg_mode(msix_en_i || msi_en_i),
  .pend_now(pend_now)
);

// File: tb/sim_hp_slot_ctrl.sv
`timescale 1ns/1ps
module sim_hp_slot_ctrl;
  localparam logic [9:0] SA = 10'h006;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0;
  logic [9:0]  wr_addr = SA;
  logic [3:0]  wr_be = 0;
  logic [31:0] wr_data = 0;
  logic [9:0]  rd_addr = SA;
  logic [31:0] rd_data;
  logic        ins = 0, rem = 0, boot = 0, btn = 0;
  logic        msix = 0, msi = 0;
  logic [4:0]  mnum = 5'd0;
  logic        req, intx, busy;
  logic [4:0]  vec;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference state
  logic [15:0] m_ctl = 16'h03C0, m_sts = 16'h0;
  logic        m_pend_q = 0, m_req = 0, m_intx = 0, m_busy = 0, m_touch = 0;
  logic [4:0]  m_vec = 0;

  always #2 clk = ~clk;

  hp_slot_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_wr_en_i(wr_en), .cfg_wr_addr_i(wr_addr), .cfg_wr_be_i(wr_be),
    .cfg_wr_data_i(wr_data), .cfg_rd_addr_i(rd_addr), .cfg_rd_data_o(rd_data),
    .card_insert_i(ins), .card_remove_i(rem), .card_boot_i(boot), .attn_press_i(btn),
    .msix_en_i(msix), .msi_en_i(msi), .msg_num_i(mnum),
    .msg_req_o(req), .msg_vec_o(vec), .intx_o(intx), .busy_o(busy)
  );

  function automatic logic f_pend(logic [15:0] c, logic [15:0] s);
    return c[5] && (|(c & s & 16'h0019));
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic        pn, chg, mm, hit, cw, sw;
    logic [31:0] bm;
    logic [15:0] ns;
    pn  = f_pend(m_ctl, m_sts);
    chg = pn != m_pend_q;
    mm  = msix || msi;
    m_req = chg && mm;
    if (chg && mm) m_vec = mnum;
    if (!mm) begin
      if (chg) m_intx = pn;
      else if (m_touch && !pn) m_intx = 0;
    end
    m_pend_q = pn;
    hit = wr_en && (wr_addr == SA);
    cw  = hit && (wr_be[0] || wr_be[1]);
    sw  = hit && (wr_be[2] || wr_be[3]);
    for (int b = 0; b < 4; b++) bm[8*b +: 8] = {8{wr_be[b]}};
    ns = m_sts;
    if (sw) ns = ns & ~(wr_data[31:16] & bm[31:16] & 16'h0019);
    if (cw) begin
      if (wr_data[11] && wr_be[1]) ns[7] = ~m_sts[7];
      ns[4] = 1'b1;
      m_ctl = (m_ctl & ~(16'h03F9 & bm[15:0])) | (wr_data[15:0] & bm[15:0] & 16'h03F9);
    end
    if (boot) ns[6] = 1'b1;
    m_busy = 0;
    if (ins || rem) begin
      if (m_sts[7]) m_busy = 1;
      else begin ns[6] = !rem; ns[3] = 1'b1; end
    end
    if (btn) ns[0] = 1'b1;
    m_sts = ns;
    m_touch = sw;
  endtask

  task automatic tick(input string tag);
    logic [31:0] exp_rd;
    @(posedge clk);
    #1;
    model_edge();
    exp_rd = (rd_addr == SA) ? {m_sts, m_ctl} : 32'h0;
    chk(rd_data === exp_rd, {tag, " regs"}, rd_data, exp_rd);
    chk(req === m_req, {tag, " msg_req"}, 32'(req), 32'(m_req));
    if (m_req) chk(vec === m_vec, {tag, " msg_vec"}, 32'(vec), 32'(m_vec));
    chk(intx === m_intx, {tag, " intx"}, 32'(intx), 32'(m_intx));
    chk(busy === m_busy, {tag, " busy"}, 32'(busy), 32'(m_busy));
    @(negedge clk);
    wr_en = 0; ins = 0; rem = 0; boot = 0; btn = 0;
  endtask

  task automatic cfg_write(input logic [3:0] be, input logic [31:0] d, input string tag);
    wr_en = 1; wr_addr = SA; wr_be = be; wr_data = d;
    tick(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(rd_data === 32'h0000_03C0, "R1 reset regs", rd_data, 32'h0000_03C0);
    chk({req, intx, busy} === 3'b000, "R1 reset outputs", 32'({req, intx, busy}), 32'h0);
    // R12 other address
    rd_addr = 10'h007; #1;
    chk(rd_data === 32'h0, "R12 other address", rd_data, 32'h0);
    rd_addr = SA;
    @(negedge clk);

    // INTx mode
    cfg_write(4'b0011, 32'h0000_F7FF, "R2");
    chk(rd_data[15:0] === 16'h03F9, "R2 control mask", 32'(rd_data[15:0]), 32'h03F9);
    chk(rd_data[20] === 1'b1, "R3 command completed", 32'(rd_data[20]), 32'h1);
    tick("R11");
    chk(intx === 1'b1, "R11 intx raised", 32'(intx), 32'h1);
    cfg_write(4'b1100, 32'h00D0_0000, "R5");
    chk(rd_data[31:16] === 16'h0000, "R5 w1c", 32'(rd_data[31:16]), 32'h0);
    tick("R11");
    chk(intx === 1'b0, "R11 intx dropped", 32'(intx), 32'h0);
    ins = 1; tick("R6");
    chk(rd_data[22] && rd_data[19], "R6 insert", rd_data, 32'h0048_0000);
    // write-one-to-clear PDC with insert in same cycle
    ins = 1; wr_en = 1; wr_be = 4'b0100; wr_data = 32'h0008_0000; tick("R9");
    chk(rd_data[19] === 1'b1, "R9 raise beats clear", 32'(rd_data[19]), 32'h1);
    // combined write clears CC while commanding: CC stays set
    cfg_write(4'b1111, 32'h0010_03F9, "R3");
    chk(rd_data[20] === 1'b1, "R3 completion beats clear", 32'(rd_data[20]), 32'h1);
    cfg_write(4'b0010, 32'h0000_0B00, "R4");
    chk(rd_data[23] === 1'b1, "R4 interlock on", 32'(rd_data[23]), 32'h1);
    rem = 1; tick("R7");
    chk(busy === 1'b1, "R7 busy", 32'(busy), 32'h1);
    chk(rd_data[22] === 1'b1, "R7 state kept", 32'(rd_data[22]), 32'h1);
    cfg_write(4'b0010, 32'h0000_0B00, "R4");
    chk(rd_data[23] === 1'b0, "R4 interlock off", 32'(rd_data[23]), 32'h0);
    cfg_write(4'b1100, 32'h0019_0000, "R5");
    btn = 1; tick("R8");
    chk(rd_data[16] === 1'b1, "R8 button", 32'(rd_data[16]), 32'h1);
    ins = 1; rem = 1; tick("R6");
    chk(rd_data[22] === 1'b0, "R6 remove wins", 32'(rd_data[22]), 32'h0);
    cfg_write(4'b1100, 32'h0019_0000, "R5");
    boot = 1; tick("R6");
    chk(rd_data[22] && !rd_data[19], "R6 boot presence", rd_data, 32'h0040_0000);

    // message mode
    msix = 1; mnum = 5'd21;
    tick("R10"); tick("R10");
    btn = 1; tick("R10");
    tick("R10");
    chk(req === 1'b1 && vec === 5'd21, "R10 pulse", 32'({req, vec}), 32'h35);
    btn = 1; tick("R10");
    tick("R10");
    chk(req === 1'b0, "R10 no repeat", 32'(req), 32'h0);
    wr_en = 1; wr_addr = 10'h005; wr_be = 4'hF; wr_data = 32'hFFFF_FFFF; tick("R3");
    tick("R12");

    // constrained random
    for (int cyc = 0; cyc < 4000; cyc++) begin
      logic [31:0] r;
      if (cyc % 250 == 0) begin
        r = $urandom;
        msix = r[0] & r[1]; msi = r[2] & ~r[0]; mnum = r[12:8];
      end
      r = $urandom;
      rd_addr = (r[3:0] == 0) ? 10'h00A : SA;
      if (r[6:4] < 3) begin
        wr_en = 1;
        wr_addr = (r[8:7] == 0) ? 10'h002 : SA;
        wr_be = 4'($urandom);
        wr_data = $urandom;
        if (r[11:9] != 0) wr_data[11] = 1'b0;
      end
      ins  = r[15:13] == 0;
      rem  = r[18:16] == 0;
      btn  = r[21:19] == 0;
      boot = r[27:22] == 0;
      tick("R9");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule